// File: doc/BRIEF.md
# NAND Address Cycle Sequencer

This block turns one addressing request into the series of byte-wide address cycles that a NAND flash device expects after a command byte. A request carries two flags and a page number. One flag asks for the column part and the other for the row (page) part. Column cycles always carry zero. The row cycles carry the page number, least-significant byte first.

The cycle count is worked out when the request is accepted. A device with 2 KB pages takes two column cycles and a device with 512 B pages takes one. Either kind takes two or three row cycles, depending on whether the configured device size reaches a density threshold. That threshold is 256 MB for large-page devices and 64 MB for small-page devices.

Cycles leave through a valid/ready byte stream. A last marker flags the cycle after which the caller should wait for the device to complete. The block raises busy for the whole request and pulses done once the request has finished.

Top module: `nand_addr_seq`

## Requirements
- R1: After reset, busy, ab_valid, ab_last and done are all 0.
- R2: Every column cycle carries 0x00. A small-page request (big_page=0) sends one column cycle and a large-page request (big_page=1) sends two. Column cycles come before any row cycle.
- R3: Row cycles carry page_num bits 7:0 first, then bits 15:8, then bits 23:16 when a third row cycle is sent.
- R4: With big_page=1, a third row cycle is sent only when dev_mb >= 256. Otherwise two row cycles are sent.
- R5: With big_page=0, a third row cycle is sent only when dev_mb >= 64. Otherwise two row cycles are sent.
- R6: In a request without a page part, ab_last is 1 on the first column cycle and 0 on any later column cycle.
- R7: In a request with a page part, ab_last is 1 on the final row cycle only.
- R8: While ab_valid=1 and ab_ready=0, ab_data and ab_last hold their values on the next cycle.
- R9: A request with neither part sends no cycles. It pulses done for one cycle, in the cycle after start, and busy stays 0.
- R10: busy rises the cycle after an accepted start. It falls, with done pulsing for one cycle, in the cycle after the final cycle is accepted. A start received while busy is ignored and does not change the cycle sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| col_req | input | 1 | Request includes the column cycles |
| page_req | input | 1 | Request includes the row cycles |
| page_num | input | PAGE_W | Page number for the row cycles |
| big_page | input | 1 | 1: 2 KB page device, 0: 512 B page device |
| dev_mb | input | SIZE_W | Device size in megabytes |
| ab_data | output | 8 | Address byte |
| ab_valid | output | 1 | Address byte is valid |
| ab_ready | input | 1 | Receiver accepts the byte |
| ab_last | output | 1 | Marks the cycle to wait on for completion |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse when a request completes |

## Verification
The assertions take two things for granted. The receiver may stall at any time. The configuration inputs (big_page, dev_mb, page_num) matter only in the cycle where start is taken, because the block latches what it needs at that point. The stimulus changes inputs only on falling clock edges. It drives ab_ready from a stall pattern that varies from test to test, so that both held and flowing transfers occur. It changes the request inputs freely while busy, both to confirm that the latched request is the one being sent and to confirm that a second start is ignored.

// File: rtl/nand_addr_seq.sv
module nand_addr_seq #(
  parameter int PAGE_W = 24,
  parameter int SIZE_W = 16,
  parameter int LP_MB  = 256,
  parameter int SP_MB  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              col_req,
  input  logic              page_req,
  input  logic [PAGE_W-1:0] page_num,
  input  logic              big_page,
  input  logic [SIZE_W-1:0] dev_mb,
  output logic [7:0]        ab_data,
  output logic              ab_valid,
  input  logic              ab_ready,
  output logic              ab_last,
  output logic              busy,
  output logic              done
);

  localparam int RW = 24;

  logic [2:0]    idx, ncol_q, total_q;
  logic [RW-1:0] page_q;
  logic          pg_q, busy_q, done_q;

  wire       third   = big_page ? (dev_mb >= SIZE_W'(LP_MB)) : (dev_mb >= SIZE_W'(SP_MB));
  wire [2:0] ncol    = col_req  ? (big_page ? 3'd2 : 3'd1) : 3'd0;
  wire [2:0] nrow    = page_req ? (third ? 3'd3 : 3'd2) : 3'd0;
  wire [2:0] total   = ncol + nrow;
  wire       take    = start && !busy_q;
  wire       fire    = busy_q && ab_ready;
  wire       final_c = (idx == total_q - 3'd1);
  wire [2:0] row_i   = idx - ncol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      idx     <= '0;
      ncol_q  <= '0;
      total_q <= '0;
      page_q  <= '0;
      pg_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        idx     <= '0;
        ncol_q  <= ncol;
        total_q <= total;
        page_q  <= RW'(page_num);
        pg_q    <= page_req;
        if (total == 3'd0) done_q <= 1'b1;
        else               busy_q <= 1'b1;
      end else if (fire) begin
        if (final_c) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx <= idx + 3'd1;
        end
      end
    end
  end

  always_comb begin
    ab_data = 8'h00;
    if (idx >= ncol_q) begin
      case (row_i)
        3'd0:    ab_data = page_q[7:0];
        3'd1:    ab_data = page_q[15:8];
        default: ab_data = page_q[23:16];
      endcase
    end
  end

  assign ab_valid = busy_q;
  assign ab_last  = busy_q && (pg_q ? final_c : (idx == 3'd0));
  assign busy     = busy_q;
  assign done     = done_q;

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    ab_valid && !ab_ready |=> ab_valid && $stable(ab_data) && $stable(ab_last));

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r10_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(ab_ready && final_c) |=> busy && $stable(total_q) && $stable(page_q));

  a_r2_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ab_valid && (idx < ncol_q) |-> ab_data == 8'h00);

  a_r7_last_final: assert property (@(posedge clk) disable iff (!rst_n)
    ab_valid && ab_last && pg_q && ab_ready |=> !busy && done);

  a_r9_empty: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !col_req && !page_req |=> done && !busy);

endmodule

// File: tb/nand_addr_seq_tb.sv
module nand_addr_seq_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, col_req = 0, page_req = 0;
  logic [23:0] page_num = 0;
  logic        big_page = 0, ab_ready = 0;
  logic [15:0] dev_mb = 0;
  logic [7:0]  ab_data;
  logic        ab_valid, ab_last, busy, done;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  nand_addr_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .col_req(col_req),
    .page_req(page_req), .page_num(page_num), .big_page(big_page), .dev_mb(dev_mb),
    .ab_data(ab_data), .ab_valid(ab_valid), .ab_ready(ab_ready), .ab_last(ab_last),
    .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // req: one request; stall pattern in spat; hit: pulse start again while busy
  task automatic run(input string req, input bit c, input bit p, input bit bp,
                     input int mb, input logic [23:0] pn, input int spat, input bit hit);
    logic [7:0] eb[6];
    bit el[6];
    int ne = 0, got = 0, cyc = 0;
    logic [7:0] hb; bit hl, held = 0;
    int nc = c ? (bp ? 2 : 1) : 0;
    int nr = p ? (((bp && mb >= 256) || (!bp && mb >= 64)) ? 3 : 2) : 0;
    for (int i = 0; i < nc; i++) begin eb[ne] = 8'h00; el[ne] = !p && i == 0; ne++; end
    for (int i = 0; i < nr; i++) begin eb[ne] = pn[8*i +: 8]; el[ne] = i == nr - 1; ne++; end
    @(negedge clk);
    col_req = c; page_req = p; big_page = bp; dev_mb = 16'(mb); page_num = pn;
    start = 1; ab_ready = 0;
    @(negedge clk);
    start = 0;
    col_req = ~c; page_req = ~p; big_page = ~bp; page_num = ~pn; dev_mb = 16'hFFFF - 16'(mb);
    if (ne == 0) begin
      chk(done && !busy && !ab_valid, {req, " R9 empty done"}, {done, busy, ab_valid}, 3'b100);
      @(negedge clk);
      chk(!done && !busy, {req, " R9 done one cycle"}, {done, busy}, 2'b00);
      return;
    end
    chk(busy && ab_valid, {req, " R10 busy after start"}, {busy, ab_valid}, 2'b11);
    while (got < ne && cyc < 100) begin
      ab_ready = ((spat >> (cyc % 8)) & 1) != 0;
      if (hit && cyc == 1) start = 1; else start = 0;
      #1;
      if (held) chk(ab_data == hb && ab_last == hl, {req, " R8 hold"}, {ab_data, ab_last}, {hb, hl});
      chk(ab_valid && busy, {req, " R10 busy during"}, {ab_valid, busy}, 2'b11);
      if (ab_ready) begin
        chk(ab_data == eb[got], {req, " R2/R3 byte"}, ab_data, eb[got]);
        chk(ab_last == el[got], {req, (p ? " R7 last" : " R6 last")}, ab_last, el[got]);
        got++; held = 0;
      end else begin
        held = 1; hb = ab_data; hl = ab_last;
      end
      cyc++;
      @(negedge clk);
    end
    start = 0; ab_ready = 0;
    chk(got == ne, {req, " count"}, got, ne);
    chk(done && !busy && !ab_valid, {req, " R10 done at end"}, {done, busy, ab_valid}, 3'b100);
    @(negedge clk);
    chk(!done && !busy, {req, " R10 done pulse"}, {done, busy}, 2'b00);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1;
    chk(!busy && !ab_valid && !ab_last && !done, "R1 reset", {busy, ab_valid, ab_last, done}, 0);
    #20 rst_n = 1;
    @(negedge clk);
    chk(!busy && !ab_valid && !done, "R1 after reset", {busy, ab_valid, done}, 0);
    run("R5 small 32MB",  1, 1, 0, 32,  24'hA1B2C3, 8'hFF, 0);
    run("R5 small 64MB",  1, 1, 0, 64,  24'h123456, 8'b1010_0110, 0);
    run("R4 large 128MB", 1, 1, 1, 128, 24'h00FE01, 8'b1100_1011, 0);
    run("R4 large 255MB", 1, 1, 1, 255, 24'h77AA55, 8'hFF, 0);
    run("R4 large 256MB", 1, 1, 1, 256, 24'h9C8D7E, 8'b0110_1101, 0);
    run("R6 large col",   1, 0, 1, 512, 24'h333333, 8'b1001_0101, 0);
    run("R6 small col",   1, 0, 0, 16,  24'h444444, 8'hFF, 0);
    run("R3 page only",   0, 1, 1, 512, 24'hC0FFEE, 8'b0101_1011, 0);
    run("R5 page small",  0, 1, 0, 63,  24'h0F0E0D, 8'hFF, 0);
    run("R9 empty",       0, 0, 1, 512, 24'h111111, 8'hFF, 0);
    run("R10 restart",    1, 1, 1, 300, 24'h5A6B7C, 8'b0010_0101, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule